// File: doc/BRIEF.md
# Serial Link Self-Test Error Monitor

This block sits on the receive side of a serial link and scores a built-in self test. While test mode is active, the far end transmits an all-zero payload. Once the local receiver reports lock, every recovered word that carries any set bit is counted as one payload error. A registered pass flag shows the result of the most recent word checked. The error count saturates instead of wrapping.

Two more counters tally CRC errors reported on the return channel. Both count only while link detect is set. The functional counter runs in every mode. The self-test counter runs only in test mode and keeps its value after test mode ends. All three counters are cleared on the rising edge of the test-mode enable and by a software clear.

The controlling state machine has three states:
- `ST_FUNC`: functional mode, no checking.
- `ST_SEEK`: test mode, waiting for lock.
- `ST_CHECK`: test mode, locked, comparing words.

It has four named transitions:
- T_ENTER: `ST_FUNC` to `ST_SEEK`, or to `ST_CHECK` if lock is already present, when the enable rises.
- T_LOCK: `ST_SEEK` to `ST_CHECK`.
- T_UNLOCK: `ST_CHECK` to `ST_SEEK`.
- T_EXIT: any state to `ST_FUNC` when the enable is low.

Top module: `bist_err_mon`

## Requirements
- R1: After reset, `pass` is 1, all three counters are 0, and the state machine is in `ST_FUNC`.
- R2: In `ST_CHECK`, with `rx_lock` high, a valid word (`rx_valid`=1) is checked. A word with any set bit drives `pass` to 0 on the next edge and adds exactly 1 to `pay_err_cnt`, whatever the number of set bits. A zero word drives `pass` to 1. Without `rx_valid`, `pass` holds.
- R3: No word is checked while `rx_lock` is low, or in the first cycle after lock rises, when the state is still `ST_SEEK`. Such words leave `pay_err_cnt` unchanged and `pass` at 1.
- R4: `pass` is 1 on the edge after any cycle with `test_en` low, or with the state machine outside `ST_CHECK`.
- R5: A `crc_err` pulse adds 1 only when `link_det` is high.
  - `func_crc_cnt` counts in every mode.
  - `bist_crc_cnt` counts only while `test_en` is high.
  - Both CRC counters are 8 bits wide.
- R6: A rising edge of `test_en` (0 to 1) clears all three counters on the next edge. An increment requested in that same cycle is dropped.
- R7: After `test_en` falls, `bist_crc_cnt` and `pay_err_cnt` keep the last run's values until a software clear or the next entry into test mode.
- R8: `sw_clr` high clears all three counters on the next edge and wins over any increment in the same cycle.
- R9: Every counter stops at its all-ones value (255 for 8 bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Self-test mode enable |
| rx_lock | input | 1 | Receiver lock on the incoming stream |
| rx_valid | input | 1 | Recovered word strobe |
| rx_data | input | DATA_W | Recovered payload word |
| link_det | input | 1 | Return-channel link detect |
| crc_err | input | 1 | Return-channel CRC error pulse, one per error |
| sw_clr | input | 1 | Software clear of all counters |
| pass | output | 1 | Live pass flag |
| pay_err_cnt | output | PAY_CNT_W | Saturating payload error count |
| bist_crc_cnt | output | CRC_CNT_W | Test-mode CRC error count |
| func_crc_cnt | output | CRC_CNT_W | Functional CRC error count |

## Verification
The assertions take for granted that:
- every input is synchronous to `clk` and stays steady for a whole cycle;
- `crc_err` marks one error per high cycle;
- `rx_data` carries meaning only when `rx_valid` is high.

The stimulus changes every input on the falling edge only, and holds each value for a full clock period. It raises each error pulse for exactly one cycle per intended error. It drives nonzero data freely in cycles where checking must not occur, so that the gating is what keeps it out of the counters.

// File: rtl/bist_mon_pkg.sv
package bist_mon_pkg;

    typedef enum logic [1:0] {
        ST_FUNC  = 2'd0,
        ST_SEEK  = 2'd1,
        ST_CHECK = 2'd2
    } mon_state_t;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CMAX)) begin
            count <= count + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX) && inc && !clr |=> count == CMAX); // R9

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R8

endmodule

// File: rtl/bist_mode_fsm.sv
module bist_mode_fsm
    import bist_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_en,
    input  logic       rx_lock,
    output mon_state_t state,
    output logic       entry,
    output logic       check_on
);

    mon_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FUNC: begin
                if (test_en) state_nx = rx_lock ? ST_CHECK : ST_SEEK;   // T_ENTER
            end
            ST_SEEK: begin
                if (!test_en)    state_nx = ST_FUNC;                    // T_EXIT
                else if (rx_lock) state_nx = ST_CHECK;                  // T_LOCK
            end
            ST_CHECK: begin
                if (!test_en)     state_nx = ST_FUNC;                   // T_EXIT
                else if (!rx_lock) state_nx = ST_SEEK;                  // T_UNLOCK
            end
            default: state_nx = ST_FUNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FUNC;
        else        state <= state_nx;
    end

    always_comb begin
        entry    = test_en && (state == ST_FUNC);
        check_on = test_en && rx_lock && (state == ST_CHECK);
    end

    AST_EXIT_TO_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> state == ST_FUNC); // R4

    AST_SEEK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        entry && !rx_lock |=> state == ST_SEEK); // R3

endmodule

// File: rtl/zero_word_check.sv
module zero_word_check #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_on,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              word_err,
    output logic              pass
);

    always_comb word_err = check_on && rx_valid && (|rx_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass <= 1'b1;
        end else if (!check_on) begin
            pass <= 1'b1;
        end else if (rx_valid) begin
            pass <= ~(|rx_data);
        end
    end

    AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !check_on |=> pass); // R4

    AST_ERR_DROPS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        word_err |=> !pass); // R2

endmodule

// File: rtl/bist_err_mon.sv
module bist_err_mon
    import bist_mon_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PAY_CNT_W = 8,
    parameter int CRC_CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_en,
    input  logic                 rx_lock,
    input  logic                 rx_valid,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic                 link_det,
    input  logic                 crc_err,
    input  logic                 sw_clr,
    output logic                 pass,
    output logic [PAY_CNT_W-1:0] pay_err_cnt,
    output logic [CRC_CNT_W-1:0] bist_crc_cnt,
    output logic [CRC_CNT_W-1:0] func_crc_cnt
);

    localparam int N_CRC = 2;   // index 0: test-mode counter, index 1: functional

    mon_state_t state;
    logic       entry;
    logic       check_on;
    logic       word_err;
    logic       cnt_clr;
    logic       crc_hit;
    logic [N_CRC-1:0]     crc_inc;
    logic [CRC_CNT_W-1:0] crc_cnt [N_CRC];

    bist_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .rx_lock  (rx_lock),
        .state    (state),
        .entry    (entry),
        .check_on (check_on)
    );

    zero_word_check #(.DATA_W(DATA_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_on (check_on),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .word_err (word_err),
        .pass     (pass)
    );

    always_comb begin
        cnt_clr    = entry || sw_clr;
        crc_hit    = crc_err && link_det;
        crc_inc[0] = crc_hit && test_en;
        crc_inc[1] = crc_hit;
    end

    sat_counter #(.W(PAY_CNT_W)) u_pay_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (word_err),
        .count (pay_err_cnt)
    );

    for (genvar g = 0; g < N_CRC; g++) begin : g_crc
        sat_counter #(.W(CRC_CNT_W)) u_crc_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (crc_inc[g]),
            .count (crc_cnt[g])
        );
    end

    assign bist_crc_cnt = crc_cnt[0];
    assign func_crc_cnt = crc_cnt[1];

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (pay_err_cnt == '0) && (bist_crc_cnt == '0) && (func_crc_cnt == '0)); // R6

    AST_CRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !link_det && !entry && !sw_clr |=> $stable(bist_crc_cnt) && $stable(func_crc_cnt)); // R5

    AST_HOLD_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en && !sw_clr |=> $stable(bist_crc_cnt) && $stable(pay_err_cnt)); // R7

    AST_NO_CHECK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_lock && !entry && !sw_clr |=> $stable(pay_err_cnt)); // R3

endmodule

// File: tb/test_bist_err_mon.sv
module test_bist_err_mon;

    localparam int DW = 16;
    localparam int CW = 8;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0, rx_lock = 1'b0, rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          link_det = 1'b0, crc_err = 1'b0, sw_clr = 1'b0;
    logic          pass;
    logic [CW-1:0] pay_err_cnt, bist_crc_cnt, func_crc_cnt;

    always #10 clk = ~clk;   // 50 MHz

    bist_err_mon #(.DATA_W(DW), .PAY_CNT_W(CW), .CRC_CNT_W(CW)) i_bist_err_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_en      (test_en),
        .rx_lock      (rx_lock),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .link_det     (link_det),
        .crc_err      (crc_err),
        .sw_clr       (sw_clr),
        .pass         (pass),
        .pay_err_cnt  (pay_err_cnt),
        .bist_crc_cnt (bist_crc_cnt),
        .func_crc_cnt (func_crc_cnt)
    );

    typedef struct {
        logic          pass;
        logic [CW-1:0] pay;
        logic [CW-1:0] bcrc;
        logic [CW-1:0] fcrc;
        string         tag;
    } exp_t;

    exp_t expq[$];
    int   n_vec  = 0;
    int   n_miss = 0;

    // reference model state: 0 functional, 1 waiting for lock, 2 checking
    int            m_st   = 0;
    logic          m_pass = 1'b1;
    logic [CW-1:0] m_pay  = '0, m_bcrc = '0, m_fcrc = '0;

    function automatic logic [CW-1:0] bump(logic [CW-1:0] v, logic clr, logic inc);
        if (clr) return '0;
        if (inc && v != CMAX) return v + 1'b1;
        return v;
    endfunction

    task automatic step(input logic te, input logic lk, input logic vl,
                        input logic [DW-1:0] d, input logic ld, input logic ce,
                        input logic sc, input string tag);
        logic entry, chk, clr;
        exp_t e;
        @(negedge clk);
        test_en = te; rx_lock = lk; rx_valid = vl; rx_data = d;
        link_det = ld; crc_err = ce; sw_clr = sc;
        entry = te && (m_st == 0);
        chk   = te && lk && (m_st == 2);
        clr   = entry || sc;
        m_pay  = bump(m_pay,  clr, chk && vl && (d != 0));
        m_bcrc = bump(m_bcrc, clr, ce && ld && te);
        m_fcrc = bump(m_fcrc, clr, ce && ld);
        if (!chk)    m_pass = 1'b1;
        else if (vl) m_pass = (d == 0);
        m_st = !te ? 0 : (lk ? 2 : 1);
        e.pass = m_pass; e.pay = m_pay; e.bcrc = m_bcrc; e.fcrc = m_fcrc; e.tag = tag;
        expq.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                n_vec++;
                if (pass !== e.pass || pay_err_cnt !== e.pay ||
                    bist_crc_cnt !== e.bcrc || func_crc_cnt !== e.fcrc) begin
                    n_miss++;
                    $display("FAIL %s: pass/pay/bcrc/fcrc actual %b/%0d/%0d/%0d expected %b/%0d/%0d/%0d",
                             e.tag, pass, pay_err_cnt, bist_crc_cnt, func_crc_cnt,
                             e.pass, e.pay, e.bcrc, e.fcrc);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 20);
        n_miss++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        n_vec++;
        if (pass !== 1'b1 || pay_err_cnt !== 0 || bist_crc_cnt !== 0 || func_crc_cnt !== 0) begin
            n_miss++;
            $display("FAIL R1: actual %b/%0d/%0d/%0d expected 1/0/0/0",
                     pass, pay_err_cnt, bist_crc_cnt, func_crc_cnt);
        end

        // R4: functional mode ignores words, pass stays high
        step(0, 1, 1, 16'h00F0, 0, 0, 0, "R4");
        step(0, 1, 1, 16'hFFFF, 0, 0, 0, "R4");
        // R5: functional CRC counting, gated by link detect
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, "R5");

        // R6: entry clears functional counter
        step(1, 0, 1, 16'h0001, 0, 0, 0, "R6");
        // R3: unlocked words ignored
        step(1, 0, 1, 16'h8000, 0, 0, 0, "R3");
        step(1, 0, 1, 16'h0101, 0, 0, 0, "R3");
        // R3: first locked cycle still seeking
        step(1, 1, 1, 16'h0003, 0, 0, 0, "R3");
        // R2: checking, one count per word
        step(1, 1, 1, 16'h0007, 0, 0, 0, "R2");
        step(1, 1, 0, 16'h0000, 0, 0, 0, "R2");
        step(1, 1, 1, 16'h0000, 0, 0, 0, "R2");
        step(1, 1, 1, 16'h4000, 0, 0, 0, "R2");
        step(1, 1, 1, 16'hFFFF, 0, 0, 0, "R2");
        step(1, 1, 1, 16'h0000, 0, 0, 0, "R2");
        // R5: test-mode CRC counting
        step(1, 1, 0, 0, 1, 1, 0, "R5");
        step(1, 1, 0, 0, 1, 1, 0, "R5");
        step(1, 1, 0, 0, 0, 1, 0, "R5");
        // R3: lock loss stops checking
        step(1, 0, 1, 16'h00FF, 0, 0, 0, "R3");
        step(1, 1, 1, 16'h00FF, 0, 0, 0, "R3");
        step(1, 1, 1, 16'h0010, 1, 1, 0, "R2");
        // R8: clear wins over increments
        step(1, 1, 1, 16'h0020, 1, 1, 1, "R8");
        step(1, 1, 1, 16'h0020, 1, 1, 0, "R8");
        step(1, 1, 0, 0, 1, 1, 0, "R8");

        // R7: exit holds test-mode results
        step(0, 1, 1, 16'h0FFF, 1, 1, 0, "R7");
        step(0, 1, 0, 0, 1, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R7");
        // R6: re-entry clears; increments in that cycle dropped
        step(1, 1, 1, 16'h0005, 1, 1, 0, "R6");
        step(1, 1, 0, 0, 0, 0, 0, "R6");

        // R9: saturation of payload and test CRC counters
        for (int i = 0; i < 300; i++) step(1, 1, 1, 16'h1000, 1, 1, 0, "R9");
        step(1, 1, 1, 16'h0000, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, "R8");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule